// File: doc/BRIEF.md
# Uncached Device-Memory Bus Request Generator

This block sits between a processor's load/store pipeline and a 64-bit AXI master port. It serves accesses to strongly ordered or device regions, where the bus must see exactly the access the program asked for. The pipeline offers one request at a time. Each request carries a direction, an access kind (byte, halfword, word, or a multi-register / doubleword group), a byte address and, for the group kind, a register count. The block then runs a single AXI read or write transaction whose address is the request address unchanged. The burst type is always incrementing, and the transfer size is never widened.

Group accesses become 32-bit incrementing bursts with one beat per register. During a group write the byte strobes and the data lanes follow each beat's word address, so they swap between the lower and upper halves of the 64-bit bus on every beat. A misaligned request, or a group with an illegal register count, never reaches the bus. The block reports it with a one-cycle alignment fault pulse instead. A request finishes after its last read beat or after its write response. The block then signals completion and accepts the next request.

Top module: `devmem_axi_req`

## Requirements
- R1: The AR/AW address equals the request address exactly, and the burst field is always incrementing (2'b01).
- R2: A byte access (kind 0) is issued with SIZE 0 and LEN 0. A byte write strobes only lane addr[2:0], and its data byte sits in that lane.
- R3: A halfword access (kind 1) is issued with SIZE 1 and LEN 0. A halfword write strobes 2'b11 shifted to addr[2:0]. An odd address faults.
- R4: A word access (kind 2) is issued with SIZE 2 and LEN 0. A word write strobes 8'h0F when addr[2] is 0 and 8'hF0 when it is 1. If addr[1:0] is nonzero the access faults.
- R5: A group access (kind 3) is issued with SIZE 2 and LEN equal to the register count minus one, for counts 1 to MAX_REGS. It faults when addr[1:0] is nonzero, when the count is 0, or when the count is above MAX_REGS.
- R6: In a group write, beat n uses word address base+4n. Its strobe and its 32-bit data lane are chosen by bit 2 of that address. Each beat takes the word present on wbeat_data when the beat is accepted, and wbeat_take marks that beat. wlast is high only on the final beat.
- R7: A faulting request produces no AR or AW handshake. fault goes high for exactly one cycle, in the cycle after acceptance, and the block is idle again in that same cycle.
- R8: req_ready is high only while idle. ARVALID and AWVALID, once raised, stay high with ADDR, SIZE and LEN stable until READY.
- R9: done pulses for one cycle. It follows the handshake of the last read beat or of the write response, and no bus activity of that request remains after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request taken this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_kind | input | 2 | 0 byte, 1 halfword, 2 word, 3 register group |
| req_addr | input | ADDR_W | Byte address |
| req_count | input | CNT_W | Register count for kind 3 |
| wbeat_data | input | 32 | Store data for the current write beat |
| wbeat_take | output | 1 | Current write beat accepted by the bus |
| arvalid | output | 1 | Read address valid |
| arready | input | 1 | Read address ready |
| araddr | output | ADDR_W | Read address |
| arburst | output | 2 | Read burst type |
| arsize | output | 3 | Read transfer size code |
| arlen | output | 8 | Read beats minus one |
| rvalid | input | 1 | Read data valid |
| rready | output | 1 | Read data ready |
| awvalid | output | 1 | Write address valid |
| awready | input | 1 | Write address ready |
| awaddr | output | ADDR_W | Write address |
| awburst | output | 2 | Write burst type |
| awsize | output | 3 | Write transfer size code |
| awlen | output | 8 | Write beats minus one |
| wvalid | output | 1 | Write data valid |
| wready | input | 1 | Write data ready |
| wdata | output | 64 | Write data, lane-placed |
| wstrb | output | 8 | Byte strobes |
| wlast | output | 1 | Final write beat |
| bvalid | input | 1 | Write response valid |
| bready | output | 1 | Write response ready |
| done | output | 1 | Request complete pulse |
| fault | output | 1 | Alignment fault pulse |

## Verification
Suppose the beat counter or the registered transfer shape were corrupted. The damage would appear on the very next data beat as a strobe in the wrong half of the bus or as shifted data, or as a wlast that comes early or never comes. A missing wlast leaves the write response pending and done never arrives. A sequencer stuck in the wrong phase shows up within one cycle, as a valid without a matching request or as req_ready held low. A wrong fault decision shows up in the cycle after acceptance, either as a missing fault pulse or as an address handshake the scoreboard did not expect. Bus stalls are applied to every channel, so stability of address fields and beat progress under back-pressure is checked as well.

// File: rtl/devmem_pkg.sv
package devmem_pkg;

    typedef enum logic [1:0] {
        ACC_BYTE  = 2'd0,
        ACC_HALF  = 2'd1,
        ACC_WORD  = 2'd2,
        ACC_MULTI = 2'd3
    } acc_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_AR,
        ST_RD,
        ST_AW,
        ST_WD,
        ST_BR
    } seq_state_e;

    localparam logic [1:0] BURST_INCR = 2'b01;
    localparam int         AXLEN_W    = 8;

    typedef struct packed {
        logic [2:0]         size;
        logic [AXLEN_W-1:0] len;
    } xfer_shape_t;

    // Byte-enable pattern for one beat of the given size at byte offset off.
    function automatic logic [7:0] lane_strobe(input logic [2:0] size, input logic [2:0] off);
        logic [7:0] base;
        case (size)
            3'd0:    base = 8'h01;
            3'd1:    base = 8'h03;
            default: base = 8'h0F;
        endcase
        return base << off;
    endfunction

    // Store data trimmed to the access width and moved to its byte lane.
    function automatic logic [63:0] lane_data(input logic [2:0] size, input logic [2:0] off,
                                              input logic [31:0] d);
        logic [31:0] m;
        case (size)
            3'd0:    m = {24'd0, d[7:0]};
            3'd1:    m = {16'd0, d[15:0]};
            default: m = d;
        endcase
        return {32'd0, m} << {off, 3'b000};
    endfunction

endpackage

// File: rtl/devmem_req_decode.sv
module devmem_req_decode
    import devmem_pkg::*;
#(
    parameter int MAX_REGS = 16,
    parameter int CNT_W    = $clog2(MAX_REGS + 1)
) (
    input  acc_kind_e        kind,
    input  logic [1:0]       addr_lo,
    input  logic [CNT_W-1:0] count,
    output xfer_shape_t      shape,
    output logic             misalign
);
    localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(MAX_REGS);
    localparam logic [CNT_W-1:0] ONE_CNT = CNT_W'(1);

    always_comb begin
        shape.size = 3'd2;
        shape.len  = '0;
        misalign   = 1'b0;
        case (kind)
            ACC_BYTE: begin
                shape.size = 3'd0;
            end
            ACC_HALF: begin
                shape.size = 3'd1;
                misalign   = addr_lo[0];
            end
            ACC_WORD: begin
                misalign = |addr_lo;
            end
            default: begin
                shape.len = AXLEN_W'(count - ONE_CNT);
                misalign  = (|addr_lo) || (count == '0) || (count > MAX_CNT);
            end
        endcase
    end
endmodule

// File: rtl/devmem_beat_ctr.sv
module devmem_beat_ctr
    import devmem_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic               adv,
    input  logic [2:0]         base_off,
    input  logic [2:0]         size,
    input  logic [AXLEN_W-1:0] len,
    output logic [2:0]         beat_off,
    output logic               beat_last
);
    logic [AXLEN_W-1:0] idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx <= '0;
        end else if (load) begin
            idx <= '0;
        end else if (adv) begin
            idx <= idx + 1'b1;
        end
    end

    // Beat n lies at base + n * bytes-per-beat; only the lane offset matters here.
    assign beat_off  = base_off + 3'(idx << size);
    assign beat_last = (idx == len);
endmodule

// File: rtl/devmem_wlane.sv
module devmem_wlane
    import devmem_pkg::*;
(
    input  logic [2:0]  size,
    input  logic [2:0]  off,
    input  logic [31:0] src,
    output logic [63:0] lane_wdata,
    output logic [7:0]  lane_wstrb
);
    assign lane_wdata = lane_data(size, off, src);
    assign lane_wstrb = lane_strobe(size, off);
endmodule

// File: rtl/devmem_axi_req.sv
module devmem_axi_req
    import devmem_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int MAX_REGS = 16,
    localparam int CNT_W   = $clog2(MAX_REGS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [CNT_W-1:0]  req_count,
    input  logic [31:0]       wbeat_data,
    output logic              wbeat_take,
    output logic              arvalid,
    input  logic              arready,
    output logic [ADDR_W-1:0] araddr,
    output logic [1:0]        arburst,
    output logic [2:0]        arsize,
    output logic [7:0]        arlen,
    input  logic              rvalid,
    output logic              rready,
    output logic              awvalid,
    input  logic              awready,
    output logic [ADDR_W-1:0] awaddr,
    output logic [1:0]        awburst,
    output logic [2:0]        awsize,
    output logic [7:0]        awlen,
    output logic              wvalid,
    input  logic              wready,
    output logic [63:0]       wdata,
    output logic [7:0]        wstrb,
    output logic              wlast,
    input  logic              bvalid,
    output logic              bready,
    output logic              done,
    output logic              fault
);
    seq_state_e        st;
    xfer_shape_t       shape_q;
    xfer_shape_t       dec_shape;
    logic              dec_bad;
    logic [ADDR_W-1:0] addr_q;
    logic              fault_q;
    logic              done_q;
    logic              accept;
    logic [2:0]        beat_off;
    logic              beat_last;
    logic              r_hs;
    logic              w_hs;

    assign accept = req_valid && (st == ST_IDLE);
    assign r_hs   = rvalid && rready;
    assign w_hs   = wvalid && wready;

    devmem_req_decode #(
        .MAX_REGS (MAX_REGS),
        .CNT_W    (CNT_W)
    ) u_decode (
        .kind     (acc_kind_e'(req_kind)),
        .addr_lo  (req_addr[1:0]),
        .count    (req_count),
        .shape    (dec_shape),
        .misalign (dec_bad)
    );

    devmem_beat_ctr u_beats (
        .clk       (clk),
        .rst       (rst),
        .load      (accept),
        .adv       (r_hs || w_hs),
        .base_off  (addr_q[2:0]),
        .size      (shape_q.size),
        .len       (shape_q.len),
        .beat_off  (beat_off),
        .beat_last (beat_last)
    );

    devmem_wlane u_wlane (
        .size       (shape_q.size),
        .off        (beat_off),
        .src        (wbeat_data),
        .lane_wdata (wdata),
        .lane_wstrb (wstrb)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            shape_q <= '0;
            addr_q  <= '0;
            fault_q <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            fault_q <= 1'b0;
            done_q  <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (req_valid) begin
                        if (dec_bad) begin
                            fault_q <= 1'b1;
                        end else begin
                            st      <= req_write ? ST_AW : ST_AR;
                            shape_q <= dec_shape;
                            addr_q  <= req_addr;
                        end
                    end
                end
                ST_AR: if (arready) st <= ST_RD;
                ST_RD: begin
                    if (rvalid && beat_last) begin
                        st     <= ST_IDLE;
                        done_q <= 1'b1;
                    end
                end
                ST_AW: if (awready) st <= ST_WD;
                ST_WD: if (wready && beat_last) st <= ST_BR;
                ST_BR: begin
                    if (bvalid) begin
                        st     <= ST_IDLE;
                        done_q <= 1'b1;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign req_ready  = (st == ST_IDLE);
    assign arvalid    = (st == ST_AR);
    assign araddr     = addr_q;
    assign arburst    = BURST_INCR;
    assign arsize     = shape_q.size;
    assign arlen      = shape_q.len;
    assign rready     = (st == ST_RD);
    assign awvalid    = (st == ST_AW);
    assign awaddr     = addr_q;
    assign awburst    = BURST_INCR;
    assign awsize     = shape_q.size;
    assign awlen      = shape_q.len;
    assign wvalid     = (st == ST_WD);
    assign wlast      = wvalid && beat_last;
    assign wbeat_take = w_hs;
    assign bready     = (st == ST_BR);
    assign done       = done_q;
    assign fault      = fault_q;
endmodule

// File: rtl/devmem_axi_req_chk.sv
module devmem_axi_req_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              arvalid,
    input logic              arready,
    input logic [ADDR_W-1:0] araddr,
    input logic [2:0]        arsize,
    input logic [7:0]        arlen,
    input logic              awvalid,
    input logic              awready,
    input logic [ADDR_W-1:0] awaddr,
    input logic [2:0]        awsize,
    input logic [7:0]        awlen,
    input logic              wvalid,
    input logic              wready,
    input logic [7:0]        wstrb,
    input logic              wlast,
    input logic              rvalid,
    input logic              rready,
    input logic              bvalid,
    input logic              bready,
    input logic              done,
    input logic              fault
);
    // R8
    ar_hold_chk: assert property (@(posedge clk) disable iff (rst)
        arvalid && !arready |=> arvalid && $stable(araddr) && $stable(arsize) && $stable(arlen));

    // R8
    aw_hold_chk: assert property (@(posedge clk) disable iff (rst)
        awvalid && !awready |=> awvalid && $stable(awaddr) && $stable(awsize) && $stable(awlen));

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !arvalid && !awvalid && !wvalid && !rready && !bready);

    // R7
    fault_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        fault |=> !fault);

    // R7
    fault_src_chk: assert property (@(posedge clk) disable iff (rst)
        fault |-> $past(req_valid && req_ready) && req_ready && !arvalid && !awvalid);

    // R6
    wstrb_width_chk: assert property (@(posedge clk) disable iff (rst)
        wvalid |-> $countones(wstrb) == (32'd1 << awsize));

    // R6
    wlast_end_chk: assert property (@(posedge clk) disable iff (rst)
        wvalid && wready && wlast |=> !wvalid);

    // R9
    done_src_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> $past((rvalid && rready) || (bvalid && bready)));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
endmodule

bind devmem_axi_req devmem_axi_req_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/devmem_axi_req_bench.sv
module devmem_axi_req_bench;
    localparam int ADDR_W   = 32;
    localparam int MAX_REGS = 16;
    localparam int CNT_W    = $clog2(MAX_REGS + 1);
    localparam logic [31:0] DBASE = 32'hA1B2C3D4;
    localparam logic [31:0] DSTEP = 32'h01010101;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic              req_valid = 1'b0;
    logic              req_ready;
    logic              req_write = 1'b0;
    logic [1:0]        req_kind = 2'd0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [CNT_W-1:0]  req_count = '0;
    logic [31:0]       wbeat_data;
    logic              wbeat_take;
    logic              arvalid, rready, awvalid, wvalid, wlast, bready, done, fault;
    logic              arready = 1'b0, awready = 1'b0, wready = 1'b0, rgap = 1'b0;
    logic              rvalid, bvalid;
    logic [ADDR_W-1:0] araddr, awaddr;
    logic [1:0]        arburst, awburst;
    logic [2:0]        arsize, awsize;
    logic [7:0]        arlen, awlen;
    logic [63:0]       wdata;
    logic [7:0]        wstrb;

    devmem_axi_req #(.ADDR_W(ADDR_W), .MAX_REGS(MAX_REGS)) u_devmem_axi_req (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_kind(req_kind), .req_addr(req_addr),
        .req_count(req_count), .wbeat_data(wbeat_data), .wbeat_take(wbeat_take),
        .arvalid(arvalid), .arready(arready), .araddr(araddr), .arburst(arburst),
        .arsize(arsize), .arlen(arlen), .rvalid(rvalid), .rready(rready),
        .awvalid(awvalid), .awready(awready), .awaddr(awaddr), .awburst(awburst),
        .awsize(awsize), .awlen(awlen), .wvalid(wvalid), .wready(wready),
        .wdata(wdata), .wstrb(wstrb), .wlast(wlast), .bvalid(bvalid),
        .bready(bready), .done(done), .fault(fault)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int gbeat  = 0;
    bit stall  = 1'b0;

    typedef struct {
        logic [31:0] addr;
        logic [2:0]  size;
        logic [7:0]  len;
        string       tag;
    } a_exp_t;

    typedef struct {
        logic [63:0] data;
        logic [7:0]  strb;
        logic        last;
        string       tag;
    } w_exp_t;

    a_exp_t arq[$];
    a_exp_t awq[$];
    w_exp_t wq[$];

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Bus slave: stall patterns, read beats, write response, store data source.
    logic [8:0] rcnt;
    logic       bpend;
    always @(posedge clk) begin
        cyc     <= cyc + 1;
        arready <= stall ? (cyc % 3 == 2) : 1'b1;
        awready <= stall ? (cyc % 4 == 1) : 1'b1;
        wready  <= stall ? (cyc % 2 == 0) : 1'b1;
        rgap    <= stall ? (cyc % 3 != 0) : 1'b1;
        if (rst) begin
            rcnt       <= '0;
            bpend      <= 1'b0;
            wbeat_data <= DBASE;
        end else begin
            if (arvalid && arready) rcnt <= 9'(arlen) + 9'd1;
            else if (rvalid && rready) rcnt <= rcnt - 9'd1;
            if (wvalid && wready && wlast) bpend <= 1'b1;
            else if (bvalid && bready) bpend <= 1'b0;
            if (wbeat_take) wbeat_data <= wbeat_data + DSTEP;
        end
    end
    assign rvalid = (rcnt != 9'd0) && rgap;
    assign bvalid = bpend;

    // Monitor: pop expected items as the design produces them.
    a_exp_t ea, ew, hold_ar, hold_aw;
    w_exp_t eb;
    bit ar_wait = 1'b0, aw_wait = 1'b0;
    always @(negedge clk) begin
        if (!rst) begin
            if (ar_wait)
                chk(arvalid && araddr == hold_ar.addr && arsize == hold_ar.size && arlen == hold_ar.len,
                    "R8", "AR held under stall", {arvalid, araddr}, {1'b1, hold_ar.addr});
            ar_wait = arvalid && !arready;
            hold_ar.addr = araddr; hold_ar.size = arsize; hold_ar.len = arlen;
            if (aw_wait)
                chk(awvalid && awaddr == hold_aw.addr && awsize == hold_aw.size && awlen == hold_aw.len,
                    "R8", "AW held under stall", {awvalid, awaddr}, {1'b1, hold_aw.addr});
            aw_wait = awvalid && !awready;
            hold_aw.addr = awaddr; hold_aw.size = awsize; hold_aw.len = awlen;

            if (arvalid && arready) begin
                if (arq.size() == 0) chk(1'b0, "R7", "unexpected AR", araddr, 0);
                else begin
                    ea = arq.pop_front();
                    chk(araddr == ea.addr && arburst == 2'b01, "R1", "AR addr/burst",
                        {arburst, araddr}, {2'b01, ea.addr});
                    chk(arsize == ea.size && arlen == ea.len, ea.tag, "AR size/len",
                        {arsize, arlen}, {ea.size, ea.len});
                end
            end
            if (awvalid && awready) begin
                if (awq.size() == 0) chk(1'b0, "R7", "unexpected AW", awaddr, 0);
                else begin
                    ew = awq.pop_front();
                    chk(awaddr == ew.addr && awburst == 2'b01, "R1", "AW addr/burst",
                        {awburst, awaddr}, {2'b01, ew.addr});
                    chk(awsize == ew.size && awlen == ew.len, ew.tag, "AW size/len",
                        {awsize, awlen}, {ew.size, ew.len});
                end
            end
            if (wvalid && wready) begin
                if (wq.size() == 0) chk(1'b0, "R6", "unexpected W beat", wdata, 0);
                else begin
                    eb = wq.pop_front();
                    chk(wdata == eb.data, eb.tag, "W data lane", wdata, eb.data);
                    chk(wstrb == eb.strb && wlast == eb.last && wbeat_take, eb.tag, "W strobe/last/take",
                        {wstrb, wlast, wbeat_take}, {eb.strb, eb.last, 1'b1});
                end
            end
        end
    end

    // Driver: queue expectations, present the request, then wait for its end.
    task automatic do_req(input bit wr, input logic [1:0] kind, input logic [31:0] addr,
                          input int cnt, input string tag);
        bit          bad;
        int          sz, beats, n;
        logic [31:0] ba, d, m;
        logic [2:0]  off;
        a_exp_t      a;
        w_exp_t      w;
        bad = (kind == 2'd1 && addr[0]) || (kind >= 2'd2 && addr[1:0] != 2'd0) ||
              (kind == 2'd3 && (cnt < 1 || cnt > MAX_REGS));
        sz    = (kind == 2'd0) ? 0 : (kind == 2'd1) ? 1 : 2;
        beats = (kind == 2'd3) ? cnt : 1;
        if (!bad) begin
            a.addr = addr; a.size = 3'(sz); a.len = 8'(beats - 1); a.tag = tag;
            if (wr) awq.push_back(a); else arq.push_back(a);
            if (wr) begin
                for (int b = 0; b < beats; b++) begin
                    ba  = addr + 32'(b * (1 << sz));
                    off = ba[2:0];
                    d   = DBASE + 32'(gbeat) * DSTEP;
                    gbeat++;
                    m = (sz == 0) ? {24'd0, d[7:0]} : (sz == 1) ? {16'd0, d[15:0]} : d;
                    w.data = 64'(m) << (8 * off);
                    w.strb = 8'(((1 << (1 << sz)) - 1) << off);
                    w.last = (b == beats - 1);
                    w.tag  = tag;
                    wq.push_back(w);
                end
            end
        end
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_kind = kind; req_addr = addr; req_count = CNT_W'(cnt);
        @(negedge clk);
        req_valid = 1'b0;
        chk(fault == bad, bad ? "R7" : tag, "fault after accept", fault, bad);
        if (bad) begin
            chk(req_ready && !arvalid && !awvalid, "R7", "idle with fault", {req_ready, arvalid, awvalid}, 3'b100);
            @(negedge clk);
            chk(!fault && req_ready, "R7", "fault single cycle", {fault, req_ready}, 2'b01);
        end else begin
            n = 0;
            while (!done && n < 400) begin
                @(negedge clk);
                n++;
            end
            chk(done, "R9", "done seen", done, 1);
            chk(arq.size() == 0 && awq.size() == 0 && wq.size() == 0, "R9", "traffic finished before done",
                arq.size() + awq.size() + wq.size(), 0);
            @(negedge clk);
            chk(!done && req_ready, "R9", "done single pulse then idle", {done, req_ready}, 2'b01);
        end
    endtask

    always @(posedge clk) begin
        if (cyc > 100000) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready && !arvalid && !awvalid && !wvalid && !fault && !done, "R8", "reset state",
            {req_ready, arvalid, awvalid, wvalid, fault, done}, 6'b100000);

        // R2 byte reads and writes at every lane
        for (int i = 0; i < 8; i++) do_req(1'b0, 2'd0, 32'h40 + 32'(i), 0, "R2");
        for (int i = 0; i < 8; i++) do_req(1'b1, 2'd0, 32'h80 + 32'(i), 0, "R2");
        // R3 halfword
        for (int i = 0; i < 4; i++) do_req(1'b1, 2'd1, 32'h90 + 32'(2 * i), 0, "R3");
        do_req(1'b0, 2'd1, 32'h92, 0, "R3");
        do_req(1'b1, 2'd1, 32'h95, 0, "R3");
        do_req(1'b0, 2'd1, 32'h91, 0, "R3");
        // R4 word
        do_req(1'b1, 2'd2, 32'hA0, 0, "R4");
        do_req(1'b1, 2'd2, 32'hA4, 0, "R4");
        do_req(1'b0, 2'd2, 32'hA4, 0, "R4");
        do_req(1'b1, 2'd2, 32'hA6, 0, "R4");
        do_req(1'b0, 2'd2, 32'hA1, 0, "R4");
        // R5 group reads at each word of a 16-byte window
        for (int i = 0; i < 4; i++) do_req(1'b0, 2'd3, 32'h100 + 32'(4 * i), 5, "R5");
        do_req(1'b0, 2'd3, 32'h102, 5, "R5");
        do_req(1'b0, 2'd3, 32'h100, 0, "R5");
        do_req(1'b1, 2'd3, 32'h100, MAX_REGS + 1, "R5");
        do_req(1'b1, 2'd3, 32'h300, MAX_REGS, "R5");
        // R6 group writes with alternating lanes, both start words
        do_req(1'b1, 2'd3, 32'h200, 7, "R6");
        do_req(1'b1, 2'd3, 32'h204, 7, "R6");
        do_req(1'b1, 2'd3, 32'h20C, 2, "R6");
        do_req(1'b1, 2'd3, 32'h204, 1, "R6");

        // R8 back-pressure on every channel
        stall = 1'b1;
        do_req(1'b0, 2'd3, 32'h408, 4, "R8");
        do_req(1'b1, 2'd3, 32'h404, 5, "R8");
        do_req(1'b1, 2'd0, 32'h407, 0, "R8");
        do_req(1'b0, 2'd1, 32'h406, 0, "R8");
        do_req(1'b1, 2'd2, 32'h40B, 0, "R8");
        stall = 1'b0;
        do_req(1'b1, 2'd1, 32'h416, 0, "R3");

        repeat (4) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule